// File: doc/BRIEF.md
# Ethernet Clock Gating and Timer Divider Control

This block sits beside an Ethernet MAC and owns the enables of its clocks. A single 32-bit control word, reached over a plain request/ready bus with no address, gives software two ways to quiet the MAC. The first is a sleep gate that stops the host bus, host slave and transmit clock enables and leaves the remote-wake path working. The second is a full-off gate that stops every enable, the timer enable included, and also blocks the remote-wake indication.

The same word also picks one of three reference clocks (crystal, PLL reference or an external RMII pad clock) to run the precision-timer domain. It holds the divide ratio for that domain and sets the direction of the clock pad. The timer divider does not make a derived clock. It makes a one-cycle tick once every N cycles of the selected reference. A new ratio crosses into the timer domain through a toggle handshake. While the handshake is in flight, a busy flag reads back high and any write is refused with an error pulse.

Top module: `enet_clk_ctrl`

## Requirements
- R1: A write accepted with bit 0 (sleep) set drives ce_hbus, ce_hslv and ce_tx low from the cycle after the write, and ce_tmr stays high. A later accepted write with bit 0 clear brings all three back high.
- R2: A write accepted with bit 1 (full off) set drives all four clock enables low and holds wake_out low even when wake_in is high. With bit 1 clear, wake_out follows wake_in.
- R3: Read-only bit 2 reads 1 when the sleep bit, the full-off bit or both are set, and 0 otherwise.
- R4: Read-only bit 3 (busy) reads 1 from the cycle after an accepted write that changes the effective divider, until the new value has reached the timer domain and been acknowledged. A write that leaves the divider unchanged does not raise busy.
- R5: A write that arrives while busy is high changes no field and no enable. The cycle after it, err pulses high for one cycle.
- R6: The divider field, bits 11:4, resets to 1. A write of 0 to it is stored and read back as 1.
- R7: With divider value N in force, tmr_tick is high for one tmr_clk cycle in every N. With N = 1 it is high on every cycle.
- R8: Bits 13:12 select the timer reference: 0 is clk_xtal, 1 is clk_pll and 2 is clk_rmii, and tmr_clk carries the selected clock. A write of code 3 keeps the previous selection. Reset selects clk_xtal.
- R9: If the selected reference clock is stopped, busy stays high after a divider change. It clears once that clock runs again.
- R10: Bit 14 drives pad_oe: 1 makes the clock pad an output and 0 makes it an input. Reset value is 0.
- R11: Bits 31:15 always read 0. Writes to them and to the read-only bits 3:2 have no effect.
- R12: A read or write request is answered by ready high for one cycle on the next cycle. Read data is registered with that response, so the reset image reads 0x00000010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request, one cycle |
| rd_en | input | 1 | Read request, one cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid with ready |
| ready | output | 1 | Response strobe for a request |
| err | output | 1 | Pulse when a write was refused because busy was high |
| clk_xtal | input | 1 | Crystal reference clock |
| clk_pll | input | 1 | PLL reference clock |
| clk_rmii | input | 1 | External RMII pad clock |
| tmr_clk | output | 1 | Selected timer reference clock |
| tmr_tick | output | 1 | Divided clock-enable tick, timer domain |
| ce_hbus | output | 1 | Host bus clock enable |
| ce_hslv | output | 1 | Host slave clock enable |
| ce_tx | output | 1 | Transmit clock enable |
| ce_tmr | output | 1 | Timer clock enable |
| wake_in | input | 1 | Remote-wake request from the MAC |
| wake_out | output | 1 | Remote-wake indication passed on |
| pad_oe | output | 1 | Clock pad direction, 1 = output |

## Verification
The hardest state to reach from the ports is a divider transfer stuck because its target clock is not running. The bench first moves the timer selection to the pad clock with a write that leaves the divider alone, so busy stays low. It then stops that clock and writes a new ratio. It reads busy repeatedly over many bus cycles, starts the clock again, and checks that busy clears and that the tick spacing matches the new ratio. Refused writes are reached by sending a second write on the cycle right after a divider change, while the handshake is still in flight.

// File: rtl/enet_clk_pkg.sv
// Shared constants and types for the Ethernet clock control block.
// Assumes a 32-bit control word; divider field width is set per instance.
package enet_clk_pkg;

    localparam int REG_W     = 32;
    localparam int BIT_SLEEP = 0;
    localparam int BIT_OFF   = 1;
    localparam int BIT_STAT  = 2;
    localparam int BIT_BUSY  = 3;
    localparam int DIV_LSB   = 4;

    typedef enum logic [1:0] {
        SRC_XTAL = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_RMII = 2'd2,
        SRC_RSVD = 2'd3
    } ref_src_e;

endpackage

// File: rtl/enet_clk_refmux.sv
// Timer reference clock selector.
// Picks one of three reference clocks by a registered select code.
// Assumes the select only changes on a register write; the code held
// in the register is never the reserved value.
module enet_clk_refmux
    import enet_clk_pkg::*;
(
    input  logic     clk_xtal,
    input  logic     clk_pll,
    input  logic     clk_rmii,
    input  ref_src_e sel,
    output logic     clk_o
);

    // Route the selected reference to the timer domain.
    always_comb begin
        case (sel)
            SRC_PLL:  clk_o = clk_pll;
            SRC_RMII: clk_o = clk_rmii;
            default:  clk_o = clk_xtal;
        endcase
    end

endmodule

// File: rtl/enet_clk_div_cdc.sv
// Divider value handover from the bus domain to the timer domain.
// A request toggle goes through two synchroniser flops into the timer
// domain, and the timer side captures the divider on the edge it sees.
// The echoed toggle returns through two flops; busy clears when it matches.
// Assumes div_in holds steady while busy is high.
module enet_clk_div_cdc #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div_in,
    output logic             busy,
    input  logic             tclk,
    input  logic             trst_n,
    output logic [DIV_W-1:0] tdiv,
    output logic             tload
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic req_t;
    logic req_s1, req_s2, req_s3;
    logic ack_s1, ack_s2;

    // Bus side: flip the request toggle for each new divider value.
    always_ff @(posedge clk) begin
        if (!rst_n) req_t <= 1'b0;
        else if (start) req_t <= ~req_t;
    end

    // Timer side: synchronise the request and keep a delayed copy for edge detect.
    always_ff @(posedge tclk) begin
        if (!trst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_t;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    assign tload = req_s2 ^ req_s3;

    // Timer side: capture the new divider when a request edge arrives.
    always_ff @(posedge tclk) begin
        if (!trst_n) tdiv <= DIV_ONE;
        else if (tload) tdiv <= div_in;
    end

    // Bus side: synchronise the acknowledge toggle (the delayed request copy).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= req_s3;
            ack_s2 <= ack_s1;
        end
    end

    assign busy = req_t ^ ack_s2;

endmodule

// File: rtl/enet_clk_tick_div.sv
// Timer-domain divider that emits a one-cycle enable every N cycles.
// Assumes tdiv is never 0; the register side turns a written 0 into 1.
// A tload pulse restarts the count so the new ratio starts cleanly.
module enet_clk_tick_div #(
    parameter int DIV_W = 8
) (
    input  logic             tclk,
    input  logic             trst_n,
    input  logic             tload,
    input  logic [DIV_W-1:0] tdiv,
    output logic             tick
);

    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt >= (tdiv - DIV_ONE));

    // Count timer cycles and wrap at the end of each period.
    always_ff @(posedge tclk) begin
        if (!trst_n)     cnt <= '0;
        else if (tload)  cnt <= '0;
        else if (at_end) cnt <= '0;
        else             cnt <= cnt + DIV_ONE;
    end

    assign tick = at_end && !tload;

endmodule

// File: rtl/enet_clk_regs.sv
// Control word, bus responder and clock enable flops.
// Accepts writes only while busy is low; a refused write raises err.
// The enables are flops loaded on the accepting edge, so each one moves
// once per write. Assumes wr_en and rd_en are never high together.
module enet_clk_regs
    import enet_clk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             busy,
    output logic [REG_W-1:0] rd_data,
    output logic             ready,
    output logic             err,
    output logic             off_q,
    output logic [DIV_W-1:0] div_q,
    output ref_src_e         src_q,
    output logic             pad_oe_q,
    output logic             start,
    output logic             ce_hbus,
    output logic             ce_hslv,
    output logic             ce_tx,
    output logic             ce_tmr
);

    localparam int SRC_LSB = DIV_LSB + DIV_W;
    localparam int BIT_OE  = SRC_LSB + 2;
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    logic             sleep_q;
    logic             wr_ok;
    logic [DIV_W-1:0] wr_div;
    logic [DIV_W-1:0] wr_div_n;
    ref_src_e         wr_src;
    logic             wr_sleep;
    logic             wr_off;
    logic [REG_W-1:0] image;
    logic             unused_bits;

    assign wr_ok    = wr_en && !busy;
    assign wr_div   = wr_data[DIV_LSB +: DIV_W];
    assign wr_div_n = (wr_div == '0) ? DIV_ONE : wr_div;
    assign wr_src   = ref_src_e'(wr_data[SRC_LSB +: 2]);
    assign wr_sleep = wr_data[BIT_SLEEP];
    assign wr_off   = wr_data[BIT_OFF];
    assign start    = wr_ok && (wr_div_n != div_q);
    assign unused_bits = ^{wr_data[REG_W-1:BIT_OE+1], wr_data[BIT_BUSY:BIT_STAT]};

    // Load the control fields on an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q  <= 1'b0;
            off_q    <= 1'b0;
            div_q    <= DIV_ONE;
            src_q    <= SRC_XTAL;
            pad_oe_q <= 1'b0;
        end else if (wr_ok) begin
            sleep_q  <= wr_sleep;
            off_q    <= wr_off;
            div_q    <= wr_div_n;
            pad_oe_q <= wr_data[BIT_OE];
            if (wr_src != SRC_RSVD) src_q <= wr_src;
        end
    end

    // Update the gated clock enables on the same accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_hbus <= 1'b1;
            ce_hslv <= 1'b1;
            ce_tx   <= 1'b1;
            ce_tmr  <= 1'b1;
        end else if (wr_ok) begin
            ce_hbus <= !(wr_sleep || wr_off);
            ce_hslv <= !(wr_sleep || wr_off);
            ce_tx   <= !(wr_sleep || wr_off);
            ce_tmr  <= !wr_off;
        end
    end

    // Build the read image from the current fields and status.
    always_comb begin
        image                    = '0;
        image[BIT_SLEEP]         = sleep_q;
        image[BIT_OFF]           = off_q;
        image[BIT_STAT]          = sleep_q || off_q;
        image[BIT_BUSY]          = busy;
        image[DIV_LSB +: DIV_W]  = div_q;
        image[SRC_LSB +: 2]      = src_q;
        image[BIT_OE]            = pad_oe_q;
    end

    // Answer each request one cycle later; flag refused writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready   <= 1'b0;
            err     <= 1'b0;
            rd_data <= '0;
        end else begin
            ready <= wr_en || rd_en;
            err   <= wr_en && busy;
            if (rd_en) rd_data <= image;
        end
    end

endmodule

// File: rtl/enet_clk_ctrl.sv
// Ethernet clock gating and timer divider control, top level.
// Joins the control word, the reference selector, the divider handover
// and the tick divider. The timer domain gets its own reset, synchronised
// from rst_n. Assumes every reference clock runs while rst_n is low.
module enet_clk_ctrl
    import enet_clk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        ready,
    output logic        err,
    input  logic        clk_xtal,
    input  logic        clk_pll,
    input  logic        clk_rmii,
    output logic        tmr_clk,
    output logic        tmr_tick,
    output logic        ce_hbus,
    output logic        ce_hslv,
    output logic        ce_tx,
    output logic        ce_tmr,
    input  logic        wake_in,
    output logic        wake_out,
    output logic        pad_oe
);

    logic             div_busy;
    logic             off_q;
    logic [DIV_W-1:0] div_q;
    ref_src_e         src_q;
    logic             div_start;
    logic [DIV_W-1:0] tdiv;
    logic             tload;
    logic             trst_s1, trst_n;

    enet_clk_regs #(.DIV_W(DIV_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wr_data  (wr_data),
        .busy     (div_busy),
        .rd_data  (rd_data),
        .ready    (ready),
        .err      (err),
        .off_q    (off_q),
        .div_q    (div_q),
        .src_q    (src_q),
        .pad_oe_q (pad_oe),
        .start    (div_start),
        .ce_hbus  (ce_hbus),
        .ce_hslv  (ce_hslv),
        .ce_tx    (ce_tx),
        .ce_tmr   (ce_tmr)
    );

    enet_clk_refmux mux_i (
        .clk_xtal (clk_xtal),
        .clk_pll  (clk_pll),
        .clk_rmii (clk_rmii),
        .sel      (src_q),
        .clk_o    (tmr_clk)
    );

    // Synchronise the reset into the timer domain.
    always_ff @(posedge tmr_clk) begin
        trst_s1 <= rst_n;
        trst_n  <= trst_s1;
    end

    enet_clk_div_cdc #(.DIV_W(DIV_W)) cdc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (div_start),
        .div_in (div_q),
        .busy   (div_busy),
        .tclk   (tmr_clk),
        .trst_n (trst_n),
        .tdiv   (tdiv),
        .tload  (tload)
    );

    enet_clk_tick_div #(.DIV_W(DIV_W)) tick_i (
        .tclk   (tmr_clk),
        .trst_n (trst_n),
        .tload  (tload),
        .tdiv   (tdiv),
        .tick   (tmr_tick)
    );

    assign wake_out = wake_in && !off_q;

endmodule

// File: rtl/enet_clk_ctrl_chk.sv
// Assertion checker for enet_clk_ctrl, attached with bind.
// Relates bus requests and the busy state to the enables, err and ready.
module enet_clk_ctrl_chk
    import enet_clk_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [31:0] wr_data,
    input logic        busy,
    input logic        ready,
    input logic        err,
    input logic        ce_hbus,
    input logic        ce_hslv,
    input logic        ce_tx,
    input logic        ce_tmr,
    input logic        wake_out
);

    // R1
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_data[BIT_SLEEP]) |=> (!ce_hbus && !ce_hslv && !ce_tx));

    // R2
    off_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy && wr_data[BIT_OFF]) |=> (!ce_hbus && !ce_hslv && !ce_tx && !ce_tmr && !wake_out));

    // R5
    refused_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> err);

    // R5
    refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> ($stable(ce_hbus) && $stable(ce_tmr)));

    // R5
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_en && busy));

    // R12
    ready_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || rd_en) |=> ready);

    // R12
    ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(wr_en || rd_en));

endmodule

bind enet_clk_ctrl enet_clk_ctrl_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wr_data  (wr_data),
    .busy     (div_busy),
    .ready    (ready),
    .err      (err),
    .ce_hbus  (ce_hbus),
    .ce_hslv  (ce_hslv),
    .ce_tx    (ce_tx),
    .ce_tmr   (ce_tmr),
    .wake_out (wake_out)
);

// File: tb/enet_clk_ctrl_tb.sv
// Directed bench for enet_clk_ctrl: one task per scenario.
module enet_clk_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ready, err;
    logic        clk_xtal = 1'b0, clk_pll = 1'b0, clk_rmii = 1'b0;
    logic        rmii_run = 1'b1;
    logic        tmr_clk, tmr_tick;
    logic        ce_hbus, ce_hslv, ce_tx, ce_tmr;
    logic        wake_in = 1'b1;
    logic        wake_out, pad_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic last_err;
    logic last_rdy;

    enet_clk_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .ready(ready), .err(err),
        .clk_xtal(clk_xtal), .clk_pll(clk_pll), .clk_rmii(clk_rmii),
        .tmr_clk(tmr_clk), .tmr_tick(tmr_tick),
        .ce_hbus(ce_hbus), .ce_hslv(ce_hslv), .ce_tx(ce_tx), .ce_tmr(ce_tmr),
        .wake_in(wake_in), .wake_out(wake_out), .pad_oe(pad_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #7 clk_xtal = ~clk_xtal;
    always #3 clk_pll = ~clk_pll;
    always begin
        #10;
        if (rmii_run) clk_rmii = ~clk_rmii;
    end

    // Control word image: sleep bit0, off bit1, divider 11:4, source 13:12, pad bit14.
    function automatic logic [31:0] img(input logic sl, input logic of, input logic [7:0] dv,
                                        input logic [1:0] sr, input logic oe);
        img = {17'b0, oe, sr, dv, 1'b0, 1'b0, of, sl};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        last_err = err;
        last_rdy = ready;
    endtask

    task automatic bus_rd(output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        last_rdy = ready;
        d = rd_data;
    endtask

    task automatic wait_idle(output logic [31:0] d);
        for (int i = 0; i < 200; i++) begin
            bus_rd(d);
            if (!d[3]) break;
        end
    endtask

    task automatic measure(input string req, input int n);
        int cnt;
        cnt = 0;
        repeat (8) @(negedge tmr_clk);
        for (int i = 0; i < 300; i++) begin
            @(negedge tmr_clk);
            if (tmr_tick) break;
        end
        for (int i = 0; i < 300; i++) begin
            @(negedge tmr_clk);
            cnt++;
            if (tmr_tick) break;
        end
        check(req, cnt, n);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_rd(d);
        check("R12 reset image", d, 32'h0000_0010);
        check("R12 ready", last_rdy, 1'b1);
        check("R1 enables after reset", {ce_hbus, ce_hslv, ce_tx, ce_tmr}, 4'hF);
        check("R10 pad after reset", pad_oe, 1'b0);
        check("R2 wake passes", wake_out, 1'b1);
        measure("R6 R7 reset divide by 1", 1);
    endtask

    task automatic t_sleep();
        logic [31:0] d;
        bus_wr(img(1, 0, 1, 0, 0));
        check("R12 write ready", last_rdy, 1'b1);
        check("R1 sleep gates", {ce_hbus, ce_hslv, ce_tx, ce_tmr}, 4'b0001);
        check("R2 wake kept in sleep", wake_out, 1'b1);
        bus_rd(d);
        check("R3 status in sleep", d[2], 1'b1);
        bus_wr(img(0, 0, 1, 0, 0));
        check("R1 sleep released", {ce_hbus, ce_hslv, ce_tx, ce_tmr}, 4'hF);
        bus_rd(d);
        check("R3 status normal", d[2], 1'b0);
    endtask

    task automatic t_off();
        logic [31:0] d;
        bus_wr(img(0, 1, 1, 0, 0));
        check("R2 off gates all", {ce_hbus, ce_hslv, ce_tx, ce_tmr}, 4'h0);
        check("R2 wake blocked", wake_out, 1'b0);
        bus_rd(d);
        check("R3 status off", d[2], 1'b1);
        bus_wr(img(1, 1, 1, 0, 0));
        bus_rd(d);
        check("R3 status both", d[2], 1'b1);
        bus_wr(img(0, 0, 1, 0, 0));
        check("R2 off released", {ce_hbus, ce_tmr, wake_out}, 3'b111);
    endtask

    task automatic t_divider();
        logic [31:0] d;
        bus_wr(img(0, 0, 8'd5, 0, 0));
        bus_rd(d);
        check("R4 busy after change", d[3], 1'b1);
        wait_idle(d);
        check("R4 busy clears", d, img(0, 0, 8'd5, 0, 0));
        measure("R7 divide by 5", 5);
        bus_wr(img(0, 0, 8'd5, 0, 1));
        bus_rd(d);
        check("R4 no busy when divider unchanged", d[3], 1'b0);
        check("R10 pad output", pad_oe, 1'b1);
        bus_wr(img(0, 0, 8'd5, 0, 0));
        check("R10 pad input", pad_oe, 1'b0);
    endtask

    task automatic t_refused();
        logic [31:0] d;
        bus_wr(img(0, 0, 8'd3, 0, 0));
        bus_wr(img(1, 1, 8'd9, 0, 1));
        check("R5 err pulse", last_err, 1'b1);
        check("R5 enables untouched", {ce_hbus, ce_tmr, pad_oe}, 3'b110);
        @(negedge clk);
        check("R5 err one cycle", err, 1'b0);
        wait_idle(d);
        check("R5 fields untouched", d, img(0, 0, 8'd3, 0, 0));
        measure("R7 divide by 3", 3);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        bus_wr(img(0, 0, 8'd0, 0, 0));
        wait_idle(d);
        check("R6 zero reads as one", d, img(0, 0, 8'd1, 0, 0));
        measure("R6 R7 zero ticks each cycle", 1);
    endtask

    task automatic t_source();
        logic [31:0] d;
        int bad;
        bus_wr(img(0, 0, 8'd1, 2'd1, 0));
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (tmr_clk !== clk_pll) bad++;
        end
        check("R8 pll selected", bad, 0);
        bus_wr(img(0, 0, 8'd1, 2'd3, 0));
        bus_rd(d);
        check("R8 code 3 holds", d[13:12], 2'd1);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (tmr_clk !== clk_pll) bad++;
        end
        check("R8 pll still selected", bad, 0);
        bus_wr(img(0, 0, 8'd1, 2'd0, 0));
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (tmr_clk !== clk_xtal) bad++;
        end
        check("R8 xtal selected", bad, 0);
    endtask

    task automatic t_stopped();
        logic [31:0] d;
        int bad;
        bus_wr(img(0, 0, 8'd1, 2'd2, 0));
        bus_rd(d);
        check("R8 rmii select no busy", d[3], 1'b0);
        bad = 0;
        for (int i = 0; i < 20; i++) begin
            #1;
            if (tmr_clk !== clk_rmii) bad++;
        end
        check("R8 rmii selected", bad, 0);
        @(negedge clk_rmii);
        rmii_run = 1'b0;
        bus_wr(img(0, 0, 8'd2, 2'd2, 0));
        repeat (50) @(negedge clk);
        bus_rd(d);
        check("R9 busy held with clock stopped", d[3], 1'b1);
        rmii_run = 1'b1;
        wait_idle(d);
        check("R9 busy clears on restart", d, img(0, 0, 8'd2, 2'd2, 0));
        measure("R7 R9 divide by 2 on rmii", 2);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_wr(32'hFFFF_800C | img(0, 0, 8'd2, 2'd0, 0));
        bus_rd(d);
        check("R11 reserved and read-only bits", d, img(0, 0, 8'd2, 2'd0, 0));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_sleep();
        t_off();
        t_divider();
        t_refused();
        t_zero();
        t_source();
        t_stopped();
        t_reserved();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule